// File: doc/BRIEF.md
# Module-Description Timing Configurator

This block runs on its own once reset is released. It reads a fixed list of module description bytes through a byte-read port. For each byte it presents an index and keeps the request up until the port returns valid data. From the twelve bytes it collects, it derives four configuration bytes for a DRAM controller: the address-map type, the end boundary of the banks, the timing byte (which includes the CAS latency field) and the refresh rate. When all four are registered, it raises `done` and holds the results.

A fresh `start` pulse drops every result, drops `done` and fetches the whole list again from the first index. This lets a new module description be evaluated without a reset. The serial bus master that fetches the bytes is outside the block, and so is the write of the results into a controller.

Top module: `spd_timing_cfg`

## Requirements
- R1: While reset is high and after its release, `done` is low and all four result bytes are zero. The first request after release asks for index 17.
- R2: Only one read is outstanding at a time. While `rd_req` is high and `rd_valid` is low, `rd_idx` stays stable. The fetch order is 17, 3, 13, 4, 31, 5, 18, 23, 25, 27, 29, 30. `rd_valid` pulses are ignored while `rd_req` is low: after `done`, they change no output and raise no request.
- R3: Map bit 7 (0x80) is set only when byte 17 is not 2, byte 3 is at least 13 and byte 13 is not 4.
- R4: When byte 17 is not 2, the column count in byte 4 ORs a field into map bits 6:5. A count of 10 or 11 gives 0x60, 9 gives 0x40 and 8 gives 0x20. Any other count, or byte 17 equal to 2, leaves the field at 0.
- R5: The bank end is taken from byte 31 by priority. The checked bits in order are 0x02, 0x01, 0x80, 0x40, 0x20, 0x10, 0x08 and 0x04, and the first set bit gives 0x80, 0x40, 0x20, 0x10, 0x08, 0x04, 0x02 or 0x01 in that order. When none of these bits is set, the bank end is 0x01.
- R6: When byte 5 equals 2, the bank end is shifted left by one and kept to 8 bits.
- R7: The CAS field is timing bits 5:4. When bit 0x10 of byte 18 is set, the field starts at 3. It becomes 2 if bit 0x08 is set and byte 23 is at most 0x75. It then becomes 1 if bit 0x04 is set and byte 25 is at most 0x75.
- R8: When bit 0x10 of byte 18 is clear, the CAS field is 2. It becomes 1 if bit 0x04 is set and byte 23 is at most 0x75.
- R9: The timing byte also sets these bits. Bit 7 is set when byte 27 exceeds 0x3C, bit 2 when byte 29 exceeds 0x3C and bit 6 when byte 30 exceeds 0x25. Bits 1:0 are 2'b10 when byte 17 is 4, 2'b01 when it is 2, and 0 otherwise. Bit 3 is always 0.
- R10: The refresh byte is 0x86 when the map byte is below 0x80, and 0x43 otherwise.
- R11: The results stay zero and `done` stays low until the second rising edge after the final byte is accepted. At that edge all four results and `done` are registered together. They then hold until the next `start`.
- R12: A `start` pulse clears `done` and the results on the next edge, even in the middle of a fetch. The fetch then restarts at index 17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that restarts the computation |
| rd_req | output | 1 | Byte read request, held until answered |
| rd_idx | output | 8 | Index of the requested byte |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Returned byte |
| map_cfg | output | 8 | Address-map type byte |
| bank_end | output | 8 | Bank end boundary, 16 MB units |
| timing_cfg | output | 8 | Timing byte with the CAS field |
| refresh_cfg | output | 8 | Refresh rate byte |
| done | output | 1 | All four results valid |

## Verification
The assertions check several rules on every cycle: the results stay zero while `done` is low, the index stays stable while a request waits, no request is raised once `done` is high, `done` holds until `start` and drops after it, the refresh byte matches the map bit, and the CAS field is never zero. The correctness of the decode rules can only be shown by the bench scenarios. These include the density priority, the bank doubling and its overflow, both CAS ladders with pass and fail limits, and the timing thresholds at their edge values. The scenarios also show the fixed fetch order under different response delays, the restart in the middle of a fetch, and spurious valid pulses being ignored.

// File: rtl/spd_cfg_pkg.sv
package spd_cfg_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NUM_READS = 12;
    localparam int unsigned RAW_W     = NUM_READS * BYTE_W;
    localparam int unsigned SLOT_W    = $clog2(NUM_READS);

    localparam logic [7:0] FAST_TCK_LIMIT = 8'h75;
    localparam logic [7:0] PRECHG_LIMIT   = 8'h3C;
    localparam logic [7:0] RCD_LIMIT      = 8'h3C;
    localparam logic [7:0] ACTIVE_LIMIT   = 8'h25;
    localparam logic [7:0] ROW_MIN        = 8'd13;

    typedef logic [BYTE_W-1:0] byte_t;

    // field order equals fetch order (first fetched is the MSB field)
    typedef struct packed {
        byte_t dev_banks;
        byte_t rows;
        byte_t width;
        byte_t cols;
        byte_t density;
        byte_t ranks;
        byte_t cas_mask;
        byte_t tck_half;
        byte_t tck_one;
        byte_t trp;
        byte_t trcd;
        byte_t tras;
    } spd_img_t;

    typedef struct packed {
        byte_t map;
        byte_t bank_end;
        byte_t timing;
        byte_t refresh;
    } cfg_set_t;

    function automatic byte_t read_index(input int unsigned slot);
        case (slot)
            0:       return 8'd17;
            1:       return 8'd3;
            2:       return 8'd13;
            3:       return 8'd4;
            4:       return 8'd31;
            5:       return 8'd5;
            6:       return 8'd18;
            7:       return 8'd23;
            8:       return 8'd25;
            9:       return 8'd27;
            10:      return 8'd29;
            11:      return 8'd30;
            default: return 8'd0;
        endcase
    endfunction

    function automatic byte_t map_type(input spd_img_t s);
        byte_t m;
        m = '0;
        if (s.dev_banks != 8'd2) begin
            if ((s.rows >= ROW_MIN) && (s.width != 8'd4))
                m[7] = 1'b1;
            case (s.cols)
                8'd10, 8'd11: m[6:5] = 2'b11;
                8'd9:         m[6:5] = 2'b10;
                8'd8:         m[6:5] = 2'b01;
                default:      m[6:5] = 2'b00;
            endcase
        end
        return m;
    endfunction

    // priority rank k -> bit of the density byte it tests
    function automatic logic [2:0] prio_bit(input int k);
        if (k == 0)      return 3'd1;
        else if (k == 1) return 3'd0;
        else             return 3'(9 - k);
    endfunction

    function automatic byte_t bank_size(input spd_img_t s);
        byte_t d;
        d = 8'h01;
        for (int k = 7; k >= 0; k--) begin
            if (s.density[prio_bit(k)])
                d = 8'h01 << (7 - k);
        end
        if (s.ranks == 8'd2)
            d = d << 1;
        return d;
    endfunction

    function automatic logic [1:0] cas_field(input spd_img_t s);
        logic [1:0] c;
        if (s.cas_mask[4]) begin
            c = 2'd3;
            if (s.cas_mask[3] && (s.tck_half <= FAST_TCK_LIMIT)) c = 2'd2;
            if (s.cas_mask[2] && (s.tck_one <= FAST_TCK_LIMIT))  c = 2'd1;
        end else begin
            c = 2'd2;
            if (s.cas_mask[2] && (s.tck_half <= FAST_TCK_LIMIT)) c = 2'd1;
        end
        return c;
    endfunction

    function automatic byte_t timing_byte(input spd_img_t s);
        logic [1:0] il;
        case (s.dev_banks)
            8'd4:    il = 2'b10;
            8'd2:    il = 2'b01;
            default: il = 2'b00;
        endcase
        return {s.trp > PRECHG_LIMIT, s.tras > ACTIVE_LIMIT, cas_field(s),
                1'b0, s.trcd > RCD_LIMIT, il};
    endfunction

    function automatic byte_t refresh_byte(input byte_t map);
        return map[7] ? 8'h43 : 8'h86;
    endfunction

endpackage

// File: rtl/spd_fetch_seq.sv
module spd_fetch_seq
    import spd_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output logic     rd_req,
    output byte_t    rd_idx,
    input  logic     rd_valid,
    input  byte_t    rd_data,
    output spd_img_t image,
    output logic     image_ready
);
    typedef enum logic [1:0] {S_FETCH, S_CALC, S_DONE} fetch_state_t;

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_READS - 1);

    fetch_state_t      state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [RAW_W-1:0]  raw_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state_q <= S_FETCH;
            slot_q  <= '0;
            raw_q   <= '0;
        end else begin
            case (state_q)
                S_FETCH: begin
                    if (rd_valid) begin
                        raw_q[(NUM_READS - 1 - int'(slot_q)) * BYTE_W +: BYTE_W] <= rd_data;
                        if (slot_q == LAST_SLOT) state_q <= S_CALC;
                        else                     slot_q  <= slot_q + 1'b1;
                    end
                end
                S_CALC:  state_q <= S_DONE;
                default: state_q <= S_DONE;
            endcase
        end
    end

    assign rd_req      = (state_q == S_FETCH);
    assign rd_idx      = read_index(32'(slot_q));
    assign image       = spd_img_t'(raw_q);
    assign image_ready = (state_q == S_CALC);
endmodule

// File: rtl/spd_cfg_calc.sv
module spd_cfg_calc
    import spd_cfg_pkg::*;
(
    input  spd_img_t image,
    output cfg_set_t cfg
);
    byte_t map_w;

    always_comb begin
        map_w        = map_type(image);
        cfg.map      = map_w;
        cfg.bank_end = bank_size(image);
        cfg.timing   = timing_byte(image);
        cfg.refresh  = refresh_byte(map_w);
    end
endmodule

// File: rtl/spd_timing_cfg.sv
module spd_timing_cfg
    import spd_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       rd_req,
    output logic [7:0] rd_idx,
    input  logic       rd_valid,
    input  logic [7:0] rd_data,
    output logic [7:0] map_cfg,
    output logic [7:0] bank_end,
    output logic [7:0] timing_cfg,
    output logic [7:0] refresh_cfg,
    output logic       done
);
    spd_img_t image_w;
    logic     image_ready_w;
    cfg_set_t calc_w;
    cfg_set_t cfg_q;
    logic     done_q;

    spd_fetch_seq u_fetch (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .rd_req      (rd_req),
        .rd_idx      (rd_idx),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .image       (image_w),
        .image_ready (image_ready_w)
    );

    spd_cfg_calc u_calc (
        .image (image_w),
        .cfg   (calc_w)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else if (image_ready_w) begin
            cfg_q  <= calc_w;
            done_q <= 1'b1;
        end
    end

    assign map_cfg     = cfg_q.map;
    assign bank_end    = cfg_q.bank_end;
    assign timing_cfg  = cfg_q.timing;
    assign refresh_cfg = cfg_q.refresh;
    assign done        = done_q;
endmodule

// File: rtl/spd_timing_cfg_chk.sv
module spd_timing_cfg_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       rd_req,
    input logic [7:0] rd_idx,
    input logic       rd_valid,
    input logic [7:0] map_cfg,
    input logic [7:0] bank_end,
    input logic [7:0] timing_cfg,
    input logic [7:0] refresh_cfg,
    input logic       done
);
    p_zero_before_done_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> (map_cfg == 8'h00 && bank_end == 8'h00 &&
                   timing_cfg == 8'h00 && refresh_cfg == 8'h00));

    p_idx_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid && !start) |=> (rd_req && $stable(rd_idx)));

    p_no_req_done_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);

    p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(map_cfg) && $stable(timing_cfg)));

    p_start_clears_r12: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && rd_req && rd_idx == 8'd17));

    p_refresh_map_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (refresh_cfg == (map_cfg[7] ? 8'h43 : 8'h86)));

    p_cas_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (timing_cfg[5:4] != 2'b00 && timing_cfg[3] == 1'b0));
endmodule

bind spd_timing_cfg spd_timing_cfg_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .rd_req      (rd_req),
    .rd_idx      (rd_idx),
    .rd_valid    (rd_valid),
    .map_cfg     (map_cfg),
    .bank_end    (bank_end),
    .timing_cfg  (timing_cfg),
    .refresh_cfg (refresh_cfg),
    .done        (done)
);

// File: tb/spd_timing_cfg_tb.sv
module spd_timing_cfg_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rd_req;
    logic [7:0] rd_idx;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] map_cfg, bank_end, timing_cfg, refresh_cfg;
    logic       done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat = 0;
    int wcnt = 0;
    int done_at = -1;
    bit exp_done = 1'b0;
    bit spur = 1'b0;
    bit finished = 1'b0;
    logic [7:0] mem [0:255];
    logic [7:0] e_map, e_bank, e_tim, e_ref;
    logic [7:0] idx_q [$];
    logic [7:0] order [12] = '{8'd17, 8'd3, 8'd13, 8'd4, 8'd31, 8'd5,
                               8'd18, 8'd23, 8'd25, 8'd27, 8'd29, 8'd30};

    spd_timing_cfg dut_i (
        .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .map_cfg(map_cfg),
        .bank_end(bank_end), .timing_cfg(timing_cfg), .refresh_cfg(refresh_cfg),
        .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model();
        logic [7:0] m, d, t;
        int cas;
        m = 8'h00;
        if (mem[17] != 8'd2) begin
            if (mem[3] >= 8'd13 && mem[13] != 8'd4) m = 8'h80;
            if (mem[4] == 8'd10 || mem[4] == 8'd11) m = m | 8'h60;
            else if (mem[4] == 8'd9) m = m | 8'h40;
            else if (mem[4] == 8'd8) m = m | 8'h20;
        end
        if (mem[31][1])      d = 8'h80;
        else if (mem[31][0]) d = 8'h40;
        else if (mem[31][7]) d = 8'h20;
        else if (mem[31][6]) d = 8'h10;
        else if (mem[31][5]) d = 8'h08;
        else if (mem[31][4]) d = 8'h04;
        else if (mem[31][3]) d = 8'h02;
        else                 d = 8'h01;
        if (mem[5] == 8'd2) d = {d[6:0], 1'b0};
        if (mem[18][4]) begin
            cas = 3;
            if (mem[18][3] && mem[23] <= 8'h75) cas = 2;
            if (mem[18][2] && mem[25] <= 8'h75) cas = 1;
        end else begin
            cas = 2;
            if (mem[18][2] && mem[23] <= 8'h75) cas = 1;
        end
        t = 8'(cas * 16);
        if (mem[27] > 8'h3C) t = t + 8'h80;
        if (mem[30] > 8'h25) t = t + 8'h40;
        if (mem[29] > 8'h3C) t = t + 8'h04;
        if (mem[17] == 8'd4) t = t + 8'h02;
        if (mem[17] == 8'd2) t = t + 8'h01;
        e_map  = m;
        e_bank = d;
        e_tim  = t;
        e_ref  = (m < 8'h80) ? 8'h86 : 8'h43;
    endtask

    task automatic load(input logic [7:0] b17, b3, b13, b4, b31, b5,
                        b18, b23, b25, b27, b29, b30);
        mem[17] = b17; mem[3] = b3; mem[13] = b13; mem[4] = b4; mem[31] = b31;
        mem[5] = b5; mem[18] = b18; mem[23] = b23; mem[25] = b25;
        mem[27] = b27; mem[29] = b29; mem[30] = b30;
    endtask

    // responder and per-cycle reference comparison, one process at negedge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (done_at >= 0 && cyc == done_at) exp_done = 1'b1;
                check("R11 done", {31'd0, done}, {31'd0, exp_done});
                check("R11 map", {24'd0, map_cfg}, exp_done ? {24'd0, e_map} : 32'd0);
                check("R11 bank", {24'd0, bank_end}, exp_done ? {24'd0, e_bank} : 32'd0);
                check("R11 timing", {24'd0, timing_cfg}, exp_done ? {24'd0, e_tim} : 32'd0);
                check("R11 refresh", {24'd0, refresh_cfg}, exp_done ? {24'd0, e_ref} : 32'd0);
                if (exp_done) check("R2 no request when done", {31'd0, rd_req}, 32'd0);
            end
            rd_valid = 1'b0;
            if (rst) wcnt = 0;
            else if (rd_req) begin
                if (wcnt >= lat) begin
                    rd_valid = 1'b1;
                    rd_data  = mem[rd_idx];
                    idx_q.push_back(rd_idx);
                    wcnt = 0;
                    if (idx_q.size() == 12) done_at = cyc + 2;
                end else wcnt++;
            end else if (spur) begin
                rd_valid = 1'b1;
                rd_data  = 8'hFF;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        #1 start = 1'b1;
        @(posedge clk);
        #1;
        start    = 1'b0;
        idx_q.delete();
        exp_done = 1'b0;
        done_at  = -1;
        model();
        @(negedge clk);
        #1;
        check("R12 start clears done", {31'd0, done}, 32'd0);
        check("R12 restart index", {24'd0, rd_idx}, 32'd17);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
        end
        #2;
        check({tag, " done reached"}, {31'd0, done}, 32'd1);
        check("R2 read count", idx_q.size(), 12);
        for (int i = 0; i < 12; i++)
            if (i < idx_q.size())
                check("R2 fetch order", {24'd0, idx_q[i]}, {24'd0, order[i]});
    endtask

    task automatic check_results(input string tm, input string tb, input string tt);
        check(tm, {24'd0, map_cfg}, {24'd0, e_map});
        check(tb, {24'd0, bank_end}, {24'd0, e_bank});
        check(tt, {24'd0, timing_cfg}, {24'd0, e_tim});
        check("R10 refresh", {24'd0, refresh_cfg}, {24'd0, e_ref});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R11 watchdog actual hang expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        // profile A: 0xE0 map, density 0x40, ladder without latency 3
        load(8'd4, 8'd13, 8'd8, 8'd10, 8'h40, 8'd1, 8'h0C, 8'h75, 8'hA0, 8'h3C, 8'h48, 8'h2D);
        model();
        repeat (3) @(negedge clk);
        check("R1 reset done low", {31'd0, done}, 32'd0);
        check("R1 reset outputs zero", {map_cfg, bank_end, timing_cfg, refresh_cfg}, 32'd0);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 first index", {24'd0, rd_idx}, 32'd17);
        wait_done("R11");
        check_results("R3 R4 map A", "R5 bank A", "R8 R9 timing A");

        // spurious valid pulses while idle
        spur = 1'b1;
        repeat (6) @(negedge clk);
        spur = 1'b0;
        #1;
        check("R2 spurious ignored map", {24'd0, map_cfg}, {24'd0, e_map});
        check("R2 spurious ignored req", {31'd0, rd_req}, 32'd0);

        // profile B: byte17=2 suppresses map, density 0x01 beats 0x80, doubled
        lat = 1;
        load(8'd2, 8'd14, 8'd8, 8'd9, 8'h81, 8'd2, 8'h1C, 8'h76, 8'h75, 8'h3D, 8'h3C, 8'h25);
        pulse_start();
        wait_done("R11");
        check_results("R3 map B", "R5 R6 bank B", "R7 R9 timing B");

        // profile C: 8 columns, no density bits, latency-3 improved to 2.5 only
        lat = 3;
        load(8'd4, 8'd12, 8'd8, 8'd8, 8'h00, 8'd2, 8'h18, 8'h50, 8'h10, 8'h00, 8'h3D, 8'h26);
        pulse_start();
        wait_done("R11");
        check_results("R4 map C", "R5 R6 bank C", "R7 R9 timing C");

        // profile D: width 4 blocks bit 7, latency 3 only, all thresholds hit
        lat = 0;
        load(8'd8, 8'd13, 8'd4, 8'd11, 8'h04, 8'd1, 8'h10, 8'h10, 8'h10, 8'hFF, 8'hFF, 8'hFF);
        pulse_start();
        wait_done("R11");
        check_results("R3 R4 map D", "R5 bank D", "R7 R9 timing D");

        // profile E with restart in mid fetch: no latency-2 bit, 7 columns, 2x overflow
        lat = 2;
        load(8'd4, 8'd13, 8'd8, 8'd7, 8'h02, 8'd2, 8'h08, 8'h10, 8'h10, 8'h3C, 8'h3C, 8'h25);
        pulse_start();
        while (idx_q.size() < 5) @(negedge clk);
        pulse_start();
        wait_done("R12");
        check_results("R4 map E", "R6 bank E", "R8 timing E");

        // profile F: byte 23 fails the limit without latency 3
        lat = 1;
        load(8'd1, 8'd13, 8'd5, 8'd9, 8'h20, 8'd1, 8'h0C, 8'h76, 8'h00, 8'h3C, 8'h3C, 8'h25);
        pulse_start();
        wait_done("R11");
        check_results("R3 R4 map F", "R5 bank F", "R8 R9 timing F");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule